// File: doc/BRIEF.md
# Three-Dimensional DMA Transfer Sequencer

This block keeps one active transfer description and turns it into a stream of address requests for a data mover. A transfer is laid out in three levels. An array is a run of contiguous bytes. A frame is a number of arrays. A block is a number of frames. Each request on the output carries one array: a source address, a destination address and a byte count. The byte movement is done downstream and is not part of this block.

A trigger pulse starts a burst of requests. The programmed sync mode sets the size of that burst: one array, the rest of the current frame, or the rest of the block. Source and destination each step with their own signed strides, one between arrays and one between frames. Each side can also be pinned to a constant address.

When the last array of the block is accepted, the block can raise a completion pulse and a chain pulse. It then replaces its active description with the entry that the description's link field selects from a small link table, so the next transfer is ready without software action. The link value of all ones selects an empty set. A trigger that arrives while the active set is empty is flagged as an error.

Top module: `dma3d_seq`

## Requirements
- R1: After reset no request is offered, no completion, chain or error pulse is raised, and the active set is empty.
- R2: Every request carries the active set's array byte count on `req_len`. The first request after arming carries the programmed start source and destination addresses.
- R3: Within a frame, each accepted request moves an incrementing side's next address by that side's signed array stride.
- R4: After the last array of a frame is accepted, an incrementing side's next address is the start address of the frame just finished plus that side's signed frame stride. It is not derived from the last array's address.
- R5: A side whose constant flag is set offers the same address on every request of the set.
- R6: The sync field decides how many requests one trigger releases. Code 0 releases one array. Code 1 releases the arrays that remain in the current frame. Codes 2 and 3 release the remainder of the block.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_src`, `req_dst` and `req_len` hold their values into the next cycle.
- R8: A trigger that arrives while requests are outstanding has no effect. A load to the active slot that arrives at that time also has no effect.
- R9: In the cycle after the handshake of the block's last array, `done_o` pulses for one cycle if the set's completion-enable bit is 1. In that same cycle `chain_o` pulses if the set's chain-enable bit is 1.
- R10: On block completion, the active set is replaced by the link table entry that its link field selects, and its counters are rearmed. A link field of all ones (7) installs the empty set.
- R11: A set with any count equal to zero is empty. A trigger to an idle block holding an empty set produces a one-cycle `trig_err_o` pulse in the next cycle and no request.
- R12: A load with `ld_sel` equal to all ones writes the active set and rearms its counters, but only while the block is idle. Any other `ld_sel` value writes that link table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load strobe for a parameter set |
| ld_sel | input | 3 | Target slot: 0..6 link table, 7 active set |
| ld_data | input | 185 | Packed parameter set (package struct `xfer_set_t`) |
| trig | input | 1 | Transfer trigger pulse |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted when high together with `req_valid` |
| req_src | output | 32 | Source address of the array |
| req_dst | output | 32 | Destination address of the array |
| req_len | output | 16 | Array byte count |
| done_o | output | 1 | Block completion pulse |
| chain_o | output | 1 | Chain trigger pulse |
| trig_err_o | output | 1 | Trigger on empty set |

## Verification
`req_valid` rises in the cycle after the clock edge that samples the trigger. Each later request appears in the cycle after the edge that accepted the one before it. `done_o`, `chain_o` and `trig_err_o` are each high in the single cycle that follows the edge that caused them. The bench drives its inputs just after a rising edge and samples at the falling edge, so every handshake and pulse is seen in the cycle it is due. The monitor compares each accepted request in order against a queue of predicted requests, and it counts pulses until the burst has drained and three idle cycles have passed.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int IDX_W  = 16;
    localparam int LINK_W = 3;
    localparam logic [LINK_W-1:0] LINK_NONE = '1;
    localparam int TBL_DEPTH = (1 << LINK_W) - 1;

    typedef enum logic [1:0] {
        SYNC_ARRAY = 2'd0,
        SYNC_FRAME = 2'd1,
        SYNC_BLOCK = 2'd2
    } sync_e;

    typedef struct packed {
        logic [ADDR_W-1:0]        src;
        logic [ADDR_W-1:0]        dst;
        logic [CNT_W-1:0]         acnt;
        logic [CNT_W-1:0]         bcnt;
        logic [CNT_W-1:0]         ccnt;
        logic signed [IDX_W-1:0]  s_astep;
        logic signed [IDX_W-1:0]  d_astep;
        logic signed [IDX_W-1:0]  s_fstep;
        logic signed [IDX_W-1:0]  d_fstep;
        logic                     s_fix;
        logic                     d_fix;
        logic [1:0]               sync;
        logic [LINK_W-1:0]        link;
        logic                     chain_en;
        logic                     irq_en;
    } xfer_set_t;

    localparam int SET_W = $bits(xfer_set_t);
endpackage

// File: rtl/dma3d_link_tbl.sv
module dma3d_link_tbl
    import dma3d_pkg::*;
#(
    parameter int DEPTH = TBL_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LINK_W-1:0] wr_idx,
    input  xfer_set_t         wr_set,
    input  logic [LINK_W-1:0] rd_idx,
    output xfer_set_t         rd_set
);
    xfer_set_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en && (32'(wr_idx) < DEPTH)) begin
            mem_q[wr_idx] <= wr_set;
        end
    end

    always_comb begin
        rd_set = '0;
        if (32'(rd_idx) < DEPTH) rd_set = mem_q[rd_idx];
    end
endmodule

// File: rtl/dma3d_addr_step.sv
module dma3d_addr_step #(
    parameter int AW = 32,
    parameter int IW = 16
) (
    input  logic [AW-1:0]        cur,
    input  logic [AW-1:0]        base,
    input  logic signed [IW-1:0] astep,
    input  logic signed [IW-1:0] fstep,
    input  logic                 fixed,
    input  logic                 frame_end,
    output logic [AW-1:0]        nxt_cur,
    output logic [AW-1:0]        nxt_base
);
    localparam int EXT = AW - IW;
    logic [AW-1:0] astep_x, fstep_x;

    always_comb begin
        astep_x  = {{EXT{astep[IW-1]}}, astep};
        fstep_x  = {{EXT{fstep[IW-1]}}, fstep};
        nxt_cur  = cur;
        nxt_base = base;
        if (!fixed) begin
            if (frame_end) begin
                nxt_base = base + fstep_x;
                nxt_cur  = base + fstep_x;
            end else begin
                nxt_cur  = cur + astep_x;
            end
        end
    end
endmodule

// File: rtl/dma3d_seq.sv
module dma3d_seq
    import dma3d_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [LINK_W-1:0] ld_sel,
    input  logic [SET_W-1:0]  ld_data,
    input  logic              trig,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_src,
    output logic [ADDR_W-1:0] req_dst,
    output logic [CNT_W-1:0]  req_len,
    output logic              done_o,
    output logic              chain_o,
    output logic              trig_err_o
);
    typedef struct packed {
        xfer_set_t         p;
        logic [ADDR_W-1:0] s_cur;
        logic [ADDR_W-1:0] s_base;
        logic [ADDR_W-1:0] d_cur;
        logic [ADDR_W-1:0] d_base;
        logic [CNT_W-1:0]  b_left;
        logic [CNT_W-1:0]  c_left;
        logic              busy;
        logic              done;
        logic              chain;
        logic              err;
    } seq_st_t;

    seq_st_t st_d, st_q;
    xfer_set_t ld_set, link_set;
    logic xfer, frame_end, blk_end, set_empty;
    logic [ADDR_W-1:0] s_nxt_cur, s_nxt_base, d_nxt_cur, d_nxt_base;

    function automatic seq_st_t arm(input xfer_set_t s);
        seq_st_t r;
        r        = '0;
        r.p      = s;
        r.s_cur  = s.src;
        r.s_base = s.src;
        r.d_cur  = s.dst;
        r.d_base = s.dst;
        r.b_left = s.bcnt;
        r.c_left = s.ccnt;
        return r;
    endfunction

    assign ld_set = xfer_set_t'(ld_data);

    dma3d_link_tbl #(.DEPTH(TBL_DEPTH)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ld_valid && (ld_sel != LINK_NONE)),
        .wr_idx (ld_sel),
        .wr_set (ld_set),
        .rd_idx (st_q.p.link),
        .rd_set (link_set)
    );

    dma3d_addr_step #(.AW(ADDR_W), .IW(IDX_W)) u_src_step (
        .cur       (st_q.s_cur),
        .base      (st_q.s_base),
        .astep     (st_q.p.s_astep),
        .fstep     (st_q.p.s_fstep),
        .fixed     (st_q.p.s_fix),
        .frame_end (frame_end),
        .nxt_cur   (s_nxt_cur),
        .nxt_base  (s_nxt_base)
    );

    dma3d_addr_step #(.AW(ADDR_W), .IW(IDX_W)) u_dst_step (
        .cur       (st_q.d_cur),
        .base      (st_q.d_base),
        .astep     (st_q.p.d_astep),
        .fstep     (st_q.p.d_fstep),
        .fixed     (st_q.p.d_fix),
        .frame_end (frame_end),
        .nxt_cur   (d_nxt_cur),
        .nxt_base  (d_nxt_base)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.chain = 1'b0;
        st_d.err   = 1'b0;
        xfer       = st_q.busy && req_ready;
        frame_end  = (st_q.b_left == CNT_W'(1));
        blk_end    = frame_end && (st_q.c_left == CNT_W'(1));
        set_empty  = (st_q.p.acnt == '0) || (st_q.p.bcnt == '0) || (st_q.p.ccnt == '0);
        if (!st_q.busy) begin
            if (ld_valid && (ld_sel == LINK_NONE)) begin
                st_d = arm(ld_set);
            end else if (trig) begin
                if (set_empty) st_d.err  = 1'b1;
                else           st_d.busy = 1'b1;
            end
        end else if (xfer) begin
            if (blk_end) begin
                st_d       = arm(link_set);
                st_d.done  = st_q.p.irq_en;
                st_d.chain = st_q.p.chain_en;
            end else begin
                st_d.s_cur  = s_nxt_cur;
                st_d.s_base = s_nxt_base;
                st_d.d_cur  = d_nxt_cur;
                st_d.d_base = d_nxt_base;
                st_d.b_left = frame_end ? st_q.p.bcnt : st_q.b_left - CNT_W'(1);
                st_d.c_left = frame_end ? st_q.c_left - CNT_W'(1) : st_q.c_left;
                if ((st_q.p.sync == SYNC_ARRAY) ||
                    ((st_q.p.sync == SYNC_FRAME) && frame_end))
                    st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_valid  = st_q.busy;
    assign req_src    = st_q.s_cur;
    assign req_dst    = st_q.d_cur;
    assign req_len    = st_q.p.acnt;
    assign done_o     = st_q.done;
    assign chain_o    = st_q.chain;
    assign trig_err_o = st_q.err;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_src) &&
                                       $stable(req_dst) && $stable(req_len))); // R7
    AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(req_valid && req_ready)); // R9
    AST_CHAIN_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        chain_o |-> ($past(req_valid && req_ready) && !req_valid)); // R9
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_err_o |-> ($past(trig) && !req_valid && !done_o)); // R11
    AST_FIX_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && st_q.p.s_fix && !blk_end) |=> $stable(req_src)); // R5
endmodule

// File: tb/dma3d_seq_tb.sv
module dma3d_seq_tb;
    import dma3d_pkg::*;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [ADDR_W-1:0] s;
        logic [ADDR_W-1:0] d;
        logic [CNT_W-1:0]  l;
    } item_t;

    logic clk = 0, rst_n = 0, ld_valid = 0, trig = 0, req_ready = 0;
    logic [LINK_W-1:0] ld_sel = '0;
    logic [SET_W-1:0]  ld_data = '0;
    logic req_valid, done_o, chain_o, trig_err_o;
    logic [ADDR_W-1:0] req_src, req_dst;
    logic [CNT_W-1:0]  req_len;

    item_t expq[$];
    xfer_set_t m_p, m_tbl[TBL_DEPTH];
    logic [ADDR_W-1:0] ms, md, mbs, mbd;
    int mb, mc;
    int checks = 0, errors = 0;
    int exp_done = 0, exp_chain = 0, exp_err = 0;
    int seen_done = 0, seen_chain = 0, seen_err = 0;

    dma3d_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel),
        .ld_data(ld_data), .trig(trig), .req_valid(req_valid),
        .req_ready(req_ready), .req_src(req_src), .req_dst(req_dst),
        .req_len(req_len), .done_o(done_o), .chain_o(chain_o),
        .trig_err_o(trig_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] sx(input logic [IDX_W-1:0] v);
        return {{(ADDR_W-IDX_W){v[IDX_W-1]}}, v};
    endfunction

    task automatic m_arm(input xfer_set_t s);
        m_p = s; ms = s.src; mbs = s.src; md = s.dst; mbd = s.dst;
        mb = int'(s.bcnt); mc = int'(s.ccnt);
    endtask

    task automatic load(input logic [LINK_W-1:0] sel, input xfer_set_t s);
        @(posedge clk); #1;
        ld_valid = 1; ld_sel = sel; ld_data = s;
        @(posedge clk); #1;
        ld_valid = 0;
        if (sel == LINK_NONE) m_arm(s);
        else m_tbl[sel] = s;
    endtask

    // reference prediction of one trigger (R2..R6, R9..R11)
    task automatic predict();
        bit fe, be;
        if (m_p.acnt == 0 || m_p.bcnt == 0 || m_p.ccnt == 0) begin
            exp_err++;
            return;
        end
        forever begin
            expq.push_back({ms, md, m_p.acnt});
            fe = (mb == 1);
            be = fe && (mc == 1);
            if (be) begin
                exp_done  += int'(m_p.irq_en);
                exp_chain += int'(m_p.chain_en);
                if (m_p.link == LINK_NONE) m_arm('0);
                else m_arm(m_tbl[m_p.link]);
                break;
            end
            if (!m_p.s_fix) begin
                if (fe) begin mbs = mbs + sx(m_p.s_fstep); ms = mbs; end
                else ms = ms + sx(m_p.s_astep);
            end
            if (!m_p.d_fix) begin
                if (fe) begin mbd = mbd + sx(m_p.d_fstep); md = mbd; end
                else md = md + sx(m_p.d_astep);
            end
            if (fe) begin mb = int'(m_p.bcnt); mc--; end
            else mb--;
            if (m_p.sync == SYNC_ARRAY || (m_p.sync == SYNC_FRAME && fe)) break;
        end
    endtask

    task automatic fire(input bit disturb, input xfer_set_t junk);
        predict();
        @(posedge clk); #1 trig = 1;
        @(posedge clk); #1 trig = 0;
        if (disturb) begin
            // R8: trigger and active-slot load while busy must be ignored
            @(posedge clk); #1;
            trig = 1; ld_valid = 1; ld_sel = LINK_NONE; ld_data = junk;
            @(posedge clk); #1;
            trig = 0; ld_valid = 0;
        end
        forever begin
            @(negedge clk);
            if (!req_valid && expq.size() == 0) break;
        end
        repeat (3) @(negedge clk);
        check(seen_done == exp_done, "R9", "done pulses", 96'(seen_done), 96'(exp_done));
        check(seen_chain == exp_chain, "R9", "chain pulses", 96'(seen_chain), 96'(exp_chain));
        check(seen_err == exp_err, "R11", "error pulses", 96'(seen_err), 96'(exp_err));
        check(expq.size() == 0, "R6", "pending requests", 96'(expq.size()), 96'(0));
    endtask

    // ready pattern driver
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            req_ready = (cyc % 3) != 1;
        end
    end

    // monitor / scoreboard
    initial begin
        item_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (req_valid && req_ready) begin
                    if (expq.size() == 0) begin
                        check(0, "R8", "unexpected request", {req_src, req_dst, req_len}, 96'(0));
                    end else begin
                        e = expq.pop_front();
                        check({req_src, req_dst, req_len} == e, "R2/R3/R4/R5",
                              "request", {req_src, req_dst, req_len}, e);
                    end
                end
                if (done_o)     seen_done++;
                if (chain_o)    seen_chain++;
                if (trig_err_o) seen_err++;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        check(0, "WATCHDOG", "timeout", 96'(0), 96'(1));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        xfer_set_t a, b, c, junk;
        m_arm('0);
        for (int i = 0; i < TBL_DEPTH; i++) m_tbl[i] = '0;

        a = '0; a.src = 32'h1000; a.dst = 32'h8000; a.acnt = 16'd4; a.bcnt = 16'd3;
        a.ccnt = 16'd2; a.s_astep = 16'sd8; a.d_astep = 16'sd16; a.s_fstep = 16'sd100;
        a.d_fstep = -16'sd40; a.sync = SYNC_ARRAY; a.link = 3'd0; a.chain_en = 1; a.irq_en = 1;

        b = '0; b.src = 32'h2000; b.dst = 32'h9000; b.acnt = 16'd8; b.bcnt = 16'd2;
        b.ccnt = 16'd2; b.s_astep = 16'sd4; b.d_astep = -16'sd8; b.s_fstep = 16'sd64;
        b.d_fstep = 16'sd32; b.s_fix = 1; b.sync = SYNC_FRAME; b.link = 3'd1; b.irq_en = 1;

        c = '0; c.src = 32'h3000; c.dst = 32'hA000; c.acnt = 16'd2; c.bcnt = 16'd2;
        c.ccnt = 16'd3; c.s_astep = 16'sd2; c.d_astep = 16'sd2; c.s_fstep = 16'sd16;
        c.d_fstep = 16'sd16; c.d_fix = 1; c.sync = SYNC_BLOCK; c.link = LINK_NONE;
        c.chain_en = 1; c.irq_en = 0;

        junk = a; junk.src = 32'hDEAD0000;

        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1
        check(!req_valid, "R1", "req_valid after reset", 96'(req_valid), 96'(0));
        check(!done_o && !chain_o && !trig_err_o, "R1", "pulses after reset",
              {done_o, chain_o, trig_err_o}, 96'(0));

        fire(0, junk);                      // R11: empty set after reset
        load(3'd0, b);                      // R12: table writes
        load(3'd1, c);
        load(LINK_NONE, a);                 // R12: active write while idle
        for (int k = 0; k < 6; k++) fire(0, junk);   // R3 R4 R6 array mode
        fire(0, junk);                      // R10: linked set B, frame mode, R5
        fire(0, junk);
        fire(1, junk);                      // R10 set C block mode, R8 disturbance
        fire(0, junk);                      // R10 link none -> R11 error

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule